// File: doc/BRIEF.md
# Digital Feedback AGC Gain Controller

This block closes a first-order automatic gain control loop around an external amplifier chain made of two coarse stages and one fine stage. It receives signed ADC samples together with a valid flag. It squares every accepted sample and adds the squares over a measurement window of a programmable length, normally one OFDM symbol plus its cyclic prefix. When the window closes, the block compares the window energy with a programmable reference energy and produces an error. The error is scaled down by a programmable power of two and rounded to whole dB. The result is limited in size and subtracted from a gain code expressed in 1 dB units. The gain code is held between 0 and 51 dB.

A decoder turns the gain code straight into amplifier stage settings. The fine stage receives the code modulo 6, in 1 dB steps. The 6 dB steps that remain fill the first coarse stage up to four steps, and any overflow goes to the second coarse stage. The gain changes only at window boundaries, so it stays constant inside a symbol. A one-cycle strobe marks each new set of stage codes.

Top module: `agc_gain_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the gain code loads `initGain`, or 51 if `initGain` exceeds 51. The same edge clears the window energy sum and the sample position. `gainUpdate` is low during reset.
- R2: A window is exactly `symbolLen` accepted samples, and a sample counts only in a cycle where `sampleValid` is high. Data in cycles where `sampleValid` is low has no effect on any window.
- R3: The window energy is the exact sum of the squared signed samples, with no wrap-around. This includes a window of 4095 full-scale samples of -512.
- R4: At each window close the step is (E - refPower + 2^(k-1)) >> k, where E is the window energy, k is `shiftK`, and >> is an arithmetic shift (flooring). When k = 0 the step is E - refPower. The step is subtracted from the gain code, so ties round toward +infinity.
- R5: The step is saturated to the range -8 to +8 dB before it is applied. The gain code never moves more than 8 in one update.
- R6: After each update the gain code is clamped to the range 0 to 51.
- R7: The outputs decode the gain code G as follows: `fineCode` = G mod 6, `coarseA` = min(G div 6, 4), and `coarseB` = G div 6 - `coarseA`. Hence G = 6·(`coarseA`+`coarseB`) + `fineCode`.
- R8: The gain code and stage codes change only together with a `gainUpdate` pulse. That pulse is high during the second cycle after the clock edge that accepts the last sample of a window.
- R9: A `symbolLen` of 0 behaves as a window length of 1.
- R10: Each window starts from an empty sum. Energy from one window never carries into the next, and a reset in the middle of a window discards the partial sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| initGain | input | 6 | Gain code loaded during reset (dB) |
| sampleValid | input | 1 | Marks a valid ADC sample |
| sampleData | input | 10 | Signed ADC sample |
| symbolLen | input | 12 | Samples per measurement window |
| refPower | input | 31 | Target energy per window |
| shiftK | input | 4 | Loop gain as a right shift of the error |
| gainCode | output | 6 | Current total gain in dB |
| coarseA | output | 3 | First coarse stage setting (6 dB steps) |
| coarseB | output | 3 | Second coarse stage setting (6 dB steps) |
| fineCode | output | 3 | Fine stage setting (1 dB steps) |
| gainUpdate | output | 1 | One-cycle strobe for new stage codes |

## Verification
The bench drives a window of 4095 full-scale negative samples. An accumulator that is too narrow, or that squares the sample as unsigned, would give a step that is wrong by many dB. It applies errors exactly half a step below zero, large errors that must saturate at 8 dB, and strings of updates that push the code against 0 and against 51. A missing clamp or missing saturation would let the code wrap or jump. It places invalid cycles carrying large data inside a window, asserts reset in the middle of a window, and uses a zero window length. A counter that ignores the valid flag or keeps a stale partial sum would make the updates arrive at the wrong time or with the wrong size. A scoreboard compares every `gainUpdate` pulse with the expected gain and decode, so a pulse that is missing, early or extra is reported.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int NUM_COARSE = 2;

  typedef struct packed {
    logic accumEn;     // sample accepted this cycle
    logic windowLast;  // accepted sample closes the window
    logic applyGain;   // window energy is ready, step the gain
  } agcStrobe_t;
endpackage

// File: rtl/agc_ctrl.sv
module agc_ctrl
  import agc_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleValid,
  input  logic [LEN_W-1:0] symbolLen,
  output agcStrobe_t       strobe
);
  logic [LEN_W-1:0] sampleCnt;
  logic [LEN_W-1:0] lastIdx;
  logic             isLast;
  logic             applyQ;

  always_comb begin
    lastIdx = (symbolLen == '0) ? '0 : symbolLen - 1'b1;
    isLast  = (sampleCnt >= lastIdx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleCnt <= '0;
      applyQ    <= 1'b0;
    end else begin
      applyQ <= sampleValid && isLast;
      if (sampleValid) sampleCnt <= isLast ? '0 : sampleCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.accumEn    = sampleValid;
    strobe.windowLast = sampleValid && isLast;
    strobe.applyGain  = applyQ;
  end

  // R2
  cnt_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && !isLast) |=> (sampleCnt == $past(sampleCnt) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> $stable(sampleCnt));
endmodule

// File: rtl/agc_datapath.sv
module agc_datapath
  import agc_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int LEN_W    = 12,
  parameter int SHIFT_W  = 4,
  parameter int GAIN_W   = 6,
  parameter int GAIN_MAX = 51,
  parameter int MAX_STEP = 8,
  localparam int ACC_W   = 2*SAMPLE_W - 1 + LEN_W,
  localparam int ERR_W   = ACC_W + 2,
  localparam int STEP_W  = GAIN_W + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  agcStrobe_t                 strobe,
  input  logic signed [SAMPLE_W-1:0] sampleData,
  input  logic [ACC_W-1:0]           refPower,
  input  logic [SHIFT_W-1:0]         shiftK,
  input  logic [GAIN_W-1:0]          initGain,
  output logic [GAIN_W-1:0]          gainCode,
  output logic                       gainUpdate
);
  localparam logic signed [ERR_W-1:0]  STEP_HI  = ERR_W'(MAX_STEP);
  localparam logic signed [ERR_W-1:0]  STEP_LO  = -ERR_W'(MAX_STEP);
  localparam logic [GAIN_W-1:0]        GMAX_U   = GAIN_W'(GAIN_MAX);
  localparam logic signed [STEP_W:0]   GMAX_S   = (STEP_W+1)'(GAIN_MAX);

  logic signed [2*SAMPLE_W-1:0] prod;
  logic [ACC_W-1:0]             accReg, energyReg, sumNext;
  logic [GAIN_W-1:0]            gainReg, gainNext, initClamp;
  logic signed [ERR_W-1:0]      errVal, half, errRound, shifted;
  logic signed [STEP_W-1:0]     stepVal;
  logic signed [STEP_W:0]       gainExt, stepExt, gainWide;
  logic                         updQ;

  always_comb begin
    prod      = sampleData * sampleData;
    sumNext   = accReg + ACC_W'($unsigned(prod));
    initClamp = (initGain > GMAX_U) ? GMAX_U : initGain;
  end

  // error scaling, rounding and saturation
  always_comb begin
    errVal   = $signed({2'b00, energyReg}) - $signed({2'b00, refPower});
    half     = (shiftK == '0) ? '0 : (ERR_W'(1) << (shiftK - 1'b1));
    errRound = errVal + half;
    shifted  = errRound >>> shiftK;
    if (shifted > STEP_HI)      stepVal = STEP_W'(STEP_HI);
    else if (shifted < STEP_LO) stepVal = STEP_W'(STEP_LO);
    else                        stepVal = STEP_W'(shifted);
  end

  // gain step and range clamp
  always_comb begin
    gainExt  = $signed({{(STEP_W+1-GAIN_W){1'b0}}, gainReg});
    stepExt  = {stepVal[STEP_W-1], stepVal};
    gainWide = gainExt - stepExt;
    if (gainWide < 0)           gainNext = '0;
    else if (gainWide > GMAX_S) gainNext = GMAX_U;
    else                        gainNext = gainWide[GAIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg    <= '0;
      energyReg <= '0;
      gainReg   <= initClamp;
      updQ      <= 1'b0;
    end else begin
      if (strobe.accumEn)    accReg <= strobe.windowLast ? '0 : sumNext;
      if (strobe.windowLast) energyReg <= sumNext;
      if (strobe.applyGain)  gainReg <= gainNext;
      updQ <= strobe.applyGain;
    end
  end

  assign gainCode   = gainReg;
  assign gainUpdate = updQ;

  // R6
  gain_range_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.accumEn |-> (gainReg <= GMAX_U));

  // R5
  step_limit_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.applyGain |=> ((int'(gainReg) <= int'($past(gainReg)) + MAX_STEP) &&
                          (int'($past(gainReg)) <= int'(gainReg) + MAX_STEP)));

  // R8
  gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.applyGain |=> $stable(gainReg));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.accumEn && !strobe.windowLast) |=> (accReg >= $past(accReg)));

  // R10
  window_restart_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.windowLast |=> (accReg == '0));
endmodule

// File: rtl/agc_decoder.sv
module agc_decoder
  import agc_pkg::*;
#(
  parameter int GAIN_W     = 6,
  parameter int STAGE_W    = 3,
  parameter int FINE_STEPS = 6,
  parameter int COARSE_MAX = 4
) (
  input  logic [GAIN_W-1:0]             gainCode,
  output logic [NUM_COARSE*STAGE_W-1:0] coarseCodes,
  output logic [STAGE_W-1:0]            fineCode
);
  logic [GAIN_W-1:0] coarseSteps;

  always_comb begin
    coarseSteps = gainCode / GAIN_W'(FINE_STEPS);
    fineCode    = STAGE_W'(gainCode % GAIN_W'(FINE_STEPS));
  end

  // stages fill in order: each takes up to COARSE_MAX steps
  for (genvar s = 0; s < NUM_COARSE; s++) begin : g_stage
    localparam logic [GAIN_W-1:0] BASE = GAIN_W'(s * COARSE_MAX);
    localparam logic [GAIN_W-1:0] TOP  = GAIN_W'((s + 1) * COARSE_MAX);
    logic [GAIN_W-1:0] remain;
    always_comb begin
      if (coarseSteps <= BASE)     remain = '0;
      else if (coarseSteps >= TOP) remain = GAIN_W'(COARSE_MAX);
      else                         remain = coarseSteps - BASE;
      coarseCodes[s*STAGE_W +: STAGE_W] = STAGE_W'(remain);
    end
  end
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import agc_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int LEN_W      = 12,
  parameter int SHIFT_W    = 4,
  parameter int GAIN_W     = 6,
  parameter int GAIN_MAX   = 51,
  parameter int MAX_STEP   = 8,
  parameter int STAGE_W    = 3,
  parameter int FINE_STEPS = 6,
  parameter int COARSE_MAX = 4,
  localparam int ACC_W     = 2*SAMPLE_W - 1 + LEN_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [GAIN_W-1:0]   initGain,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [LEN_W-1:0]    symbolLen,
  input  logic [ACC_W-1:0]    refPower,
  input  logic [SHIFT_W-1:0]  shiftK,
  output logic [GAIN_W-1:0]   gainCode,
  output logic [STAGE_W-1:0]  coarseA,
  output logic [STAGE_W-1:0]  coarseB,
  output logic [STAGE_W-1:0]  fineCode,
  output logic                gainUpdate
);
  agcStrobe_t                    strobe;
  logic [NUM_COARSE*STAGE_W-1:0] coarseCodes;

  agc_ctrl #(.LEN_W(LEN_W)) i_ctrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid),
    .symbolLen(symbolLen), .strobe(strobe)
  );

  agc_datapath #(
    .SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W), .SHIFT_W(SHIFT_W),
    .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX), .MAX_STEP(MAX_STEP)
  ) i_datapath (
    .clk(clk), .rst(rst), .strobe(strobe),
    .sampleData($signed(sampleData)), .refPower(refPower), .shiftK(shiftK),
    .initGain(initGain), .gainCode(gainCode), .gainUpdate(gainUpdate)
  );

  agc_decoder #(
    .GAIN_W(GAIN_W), .STAGE_W(STAGE_W),
    .FINE_STEPS(FINE_STEPS), .COARSE_MAX(COARSE_MAX)
  ) i_decoder (
    .gainCode(gainCode), .coarseCodes(coarseCodes), .fineCode(fineCode)
  );

  assign coarseA = coarseCodes[STAGE_W-1:0];
  assign coarseB = coarseCodes[2*STAGE_W-1:STAGE_W];

  // R7
  decode_sum_chk: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> (int'(gainCode) == FINE_STEPS * (int'(coarseA) + int'(coarseB)) + int'(fineCode)));

  // R7
  coarse_order_chk: assert property (@(posedge clk) disable iff (rst)
    (coarseB != '0) |-> (int'(coarseA) == COARSE_MAX));

  // R7
  fine_range_chk: assert property (@(posedge clk) disable iff (rst)
    gainUpdate |-> (int'(fineCode) < FINE_STEPS));
endmodule

// File: tb/test_agc_gain_ctrl.sv
module test_agc_gain_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  initGain;
  logic        sampleValid;
  logic [9:0]  sampleData;
  logic [11:0] symbolLen;
  logic [30:0] refPower;
  logic [3:0]  shiftK;
  logic [5:0]  gainCode;
  logic [2:0]  coarseA, coarseB, fineCode;
  logic        gainUpdate;

  int checks = 0;
  int errors = 0;
  int modelGain;
  int expQ[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  agc_gain_ctrl i_agc_gain_ctrl (
    .clk(clk), .rst(rst), .initGain(initGain), .sampleValid(sampleValid),
    .sampleData(sampleData), .symbolLen(symbolLen), .refPower(refPower),
    .shiftK(shiftK), .gainCode(gainCode), .coarseA(coarseA), .coarseB(coarseB),
    .fineCode(fineCode), .gainUpdate(gainUpdate)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkCodes(int g, string req);
    int st, a;
    st = g / 6;
    a  = (st > 4) ? 4 : st;
    check(int'(gainCode) == g,      {req, " gainCode"}, int'(gainCode), g);
    check(int'(fineCode) == g % 6,  {req, " R7 fine"},  int'(fineCode), g % 6);
    check(int'(coarseA) == a,       {req, " R7 coarseA"}, int'(coarseA), a);
    check(int'(coarseB) == st - a,  {req, " R7 coarseB"}, int'(coarseB), st - a);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst === 1'b0 && gainUpdate === 1'b1) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected update", 1, 0);
      end else begin
        int e;
        e = expQ.pop_front();
        checkCodes(e, "R4 scoreboard");
      end
    end
  end

  // one window: n valid samples of value val, optional idle gaps
  task automatic sendWindow(int n, int val, int gapEvery, longint rfp, int k, int len);
    longint energy, err, s;
    int g;
    symbolLen = 12'(len);
    refPower  = 31'(rfp);
    shiftK    = 4'(k);
    energy    = 0;
    for (int i = 0; i < n; i++) begin
      if (gapEvery > 0 && (i % gapEvery) == 0) begin
        sampleValid = 1'b0;
        sampleData  = 10'h1ff;  // large value, must be ignored (R2)
        @(negedge clk);
      end
      sampleValid = 1'b1;
      sampleData  = 10'(val);
      energy += longint'(val) * longint'(val);
      if (i == n - 1) begin
        err = energy - rfp;
        s   = (k == 0) ? err : ((err + (longint'(1) <<< (k - 1))) >>> k);
        if (s > 8)  s = 8;
        if (s < -8) s = -8;
        g = modelGain - int'(s);
        if (g < 0)  g = 0;
        if (g > 51) g = 51;
        modelGain = g;
        expQ.push_back(g);
      end
      @(negedge clk);
    end
    sampleValid = 1'b0;
    check(gainUpdate == 1'b0, "R8 no pulse one cycle after last", int'(gainUpdate), 0);
    @(negedge clk);
    check(gainUpdate == 1'b1, "R8 pulse two cycles after last", int'(gainUpdate), 1);
    @(negedge clk);
    check(gainUpdate == 1'b0, "R8 pulse width", int'(gainUpdate), 0);
  endtask

  initial begin
    rst = 1'b1; initGain = 6'd60; sampleValid = 1'b0; sampleData = '0;
    symbolLen = 12'd8; refPower = '0; shiftK = '0;
    repeat (3) @(negedge clk);
    // R1 clamp of initial gain
    checkCodes(51, "R1 init clamp");
    check(gainUpdate == 1'b0, "R1 no strobe in reset", int'(gainUpdate), 0);
    initGain = 6'd30;
    @(negedge clk);
    checkCodes(30, "R1 init load");
    rst = 1'b0;
    modelGain = 30;

    // R10: partial window then reset discards it
    symbolLen = 12'd8;
    sampleValid = 1'b1; sampleData = 10'd500;
    repeat (3) @(negedge clk);
    sampleValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkCodes(30, "R10 reset mid window");

    sendWindow(8, 100, 0, 80000, 4, 8);        // R4 zero error
    sendWindow(8, 200, 0, 80000, 15, 8);       // R4 rounding down -> 7
    sendWindow(8, -300, 3, 0, 15, 8);          // R2 gaps, R5 saturation
    sendWindow(8, 0, 0, 100000, 14, 8);        // R4 negative error
    for (int r = 0; r < 5; r++) sendWindow(8, 0, 0, 1000000, 0, 8);   // R6 top clamp
    for (int r = 0; r < 8; r++) sendWindow(16, -512, 0, 0, 0, 16);    // R6 bottom clamp
    sendWindow(4, 0, 0, 16384, 15, 4);         // R4 tie toward zero step
    sendWindow(1, 20, 0, 720, 6, 0);           // R9 zero length
    sendWindow(1, 20, 0, 720, 6, 0);           // R9 again
    sendWindow(4, 0, 0, 1000000, 0, 4);        // raise gain
    sendWindow(4, 128, 0, 65536 - 16384, 15, 4); // R4 exact half -> +1 step
    sendWindow(4095, -512, 0, longint'(4095) * 262144 - 5 * 32768, 15, 4095); // R3

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R8 all updates seen", expQ.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule